// File: doc/BRIEF.md
# Integer Execute Unit with Flags and HI/LO Pair

This block is the integer execute stage of a small load/store processor. Each accepted operation takes a first operand and a second operand. The second operand is either a register value or a sign-extended 16-bit immediate. Logic, shift, add and subtract operations write a 32-bit result register and refresh a four-bit condition flag word without any explicit write. Signed and unsigned multiply write a 64-bit product into a dedicated HI/LO register pair. Signed and unsigned divide also write to HI/LO, through a radix-2 iterative divider that takes 32 cycles.

Two conditions raise numbered exception requests as a single-cycle pulse: signed overflow on add or subtract, and a divide with a zero divisor. The surrounding pipeline presents an operation with `op_valid`. It must not expect any operation to be taken while `busy` is high. Register-file access, decode, memory and branching live outside this block.

Top module: `exu_core`

## Requirements
- R1: Operation codes XOR=2, OR=3 and AND=4 write the bitwise result of the two operands to `result` at the clock edge that accepts them.
- R2: Operation codes SLL=5, SRL=6 and SRA=7 shift the first operand. The shift amount is the low 5 bits of the second operand. SRA fills with the sign bit; SLL and SRL fill with zeros.
- R3: ADD=0 and SUB=1 write the sum and the difference. When `use_imm` is 1, the second operand is `imm` sign-extended to 32 bits in place of `src_b`. This applies to every operation.
- R4: `flags` holds carry in bit 0, overflow in bit 1, zero in bit 2 and sign in bit 3; bits 31..4 read 0. Codes 0..7 update these bits. Carry is the carry-out on ADD and "no borrow" (first operand unsigned >= second) on SUB; carry and overflow are 0 for logic and shift codes.
- R5: Signed overflow on ADD or SUB sets flag bit 1 and raises `exc_valid` with `exc_code` 2 for one cycle.
- R6: MULS=8 and MULU=9 write the upper half of the 64-bit signed or unsigned product to `hi` and the lower half to `lo` at the accepting edge. `result` and `flags` keep their values.
- R7: DIVS=10 and DIVU=11 put the quotient, truncated toward zero, in `lo` and the remainder in `hi`. For signed division the remainder takes the sign of the dividend.
- R8: A divide with a nonzero divisor raises `busy` from the accepting edge. `done` pulses for one cycle, with `hi`/`lo` updated and `busy` low, 32 cycles after the accepting edge. Operations presented while `busy` is high are ignored.
- R9: A divide with a zero divisor raises `exc_valid` with `exc_code` 0 for one cycle, leaves `hi` and `lo` unchanged and does not raise `busy`.
- R10: Reset (`rst_n` low) clears `result`, `flags`, `hi`, `lo`, `busy`, `done`, `exc_valid` and `exc_code` to 0. Codes 12..15 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 4 | Operation code (see R1 to R10) |
| use_imm | input | 1 | Take the second operand from `imm` |
| src_a | input | 32 | First operand |
| src_b | input | 32 | Second operand from a register |
| imm | input | 16 | Immediate field, sign-extended before use |
| result | output | 32 | Result of the last logic, shift or add/sub operation |
| flags | output | 32 | Condition flag word |
| hi | output | 32 | Upper product half or remainder |
| lo | output | 32 | Lower product half or quotient |
| busy | output | 1 | Divider is working; no operation is accepted |
| done | output | 1 | One-cycle pulse when a divide finishes |
| exc_valid | output | 1 | One-cycle exception request |
| exc_code | output | 5 | Exception number: 0 divide by zero, 2 overflow |

## Verification
The assertions watch, on every cycle, the properties that hold in every state:
- the one-cycle shape of `done`, which always comes with `busy` low;
- the final divider iteration, which is always followed by `done`;
- the overflow request, which always comes with flag bit 1 set;
- HI/LO, which hold still under a divide-by-zero request;
- the zero flag, which always agrees with the result after an update;
- that no divide ever starts while the divider is busy.

Only the bench scenarios can show the arithmetic values themselves: the carry convention, signed versus unsigned products and quotients, the remainder sign, the exact 32-cycle latency, and that work presented during `busy` is really dropped.

// File: rtl/exu_pkg.sv
package exu_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_XOR  = 4'd2,
        OP_OR   = 4'd3,
        OP_AND  = 4'd4,
        OP_SLL  = 4'd5,
        OP_SRL  = 4'd6,
        OP_SRA  = 4'd7,
        OP_MULS = 4'd8,
        OP_MULU = 4'd9,
        OP_DIVS = 4'd10,
        OP_DIVU = 4'd11
    } exu_op_e;

    localparam int EXC_W          = 5;
    localparam logic [4:0] EXC_DIV_ZERO = 5'd0;
    localparam logic [4:0] EXC_OVERFLOW = 5'd2;

    localparam int FLAG_CARRY = 0;
    localparam int FLAG_OVF   = 1;
    localparam int FLAG_ZERO  = 2;
    localparam int FLAG_SIGN  = 3;
    localparam int FLAG_BITS  = 4;

endpackage

// File: rtl/exu_alu.sv
module exu_alu
    import exu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [3:0]   op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res,
    output logic         carry,
    output logic         ovf,
    output logic         is_alu
);
    localparam int SH_W = $clog2(W);

    logic [SH_W-1:0] sh;
    logic [W:0]      add_full;
    logic [W:0]      sub_full;

    assign sh       = b[SH_W-1:0];
    assign add_full = {1'b0, a} + {1'b0, b};
    assign sub_full = {1'b0, a} - {1'b0, b};

    always_comb begin
        res    = '0;
        carry  = 1'b0;
        ovf    = 1'b0;
        is_alu = 1'b1;
        case (op)
            OP_ADD: begin
                res   = add_full[W-1:0];
                carry = add_full[W];
                ovf   = (a[W-1] == b[W-1]) && (add_full[W-1] != a[W-1]);
            end
            OP_SUB: begin
                res   = sub_full[W-1:0];
                carry = ~sub_full[W];
                ovf   = (a[W-1] != b[W-1]) && (sub_full[W-1] != a[W-1]);
            end
            OP_XOR:  res = a ^ b;
            OP_OR:   res = a | b;
            OP_AND:  res = a & b;
            OP_SLL:  res = a << sh;
            OP_SRL:  res = a >> sh;
            OP_SRA:  res = W'($signed(a) >>> sh);
            default: is_alu = 1'b0;
        endcase
    end
endmodule

// File: rtl/exu_mul.sv
module exu_mul #(
    parameter int W = 32
) (
    input  logic           signed_mode,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [2*W-1:0] prod
);
    logic [2*W-1:0] ext_a;
    logic [2*W-1:0] ext_b;

    assign ext_a = {{W{signed_mode & a[W-1]}}, a};
    assign ext_b = {{W{signed_mode & b[W-1]}}, b};
    assign prod  = ext_a * ext_b;
endmodule

// File: rtl/exu_div.sv
module exu_div #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         signed_mode,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic         done,
    output logic         fin,
    output logic [W-1:0] quo_out,
    output logic [W-1:0] rem_out
);
    localparam int CNT_W = $clog2(W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

    typedef struct packed {
        logic             busy;
        logic             done;
        logic [CNT_W-1:0] cnt;
        logic [W-1:0]     rem;
        logic [W-1:0]     quo;
        logic [W-1:0]     dvsr;
        logic             neg_q;
        logic             neg_r;
    } div_state_t;

    div_state_t st_d, st_q;
    logic [W:0]   rem_sh;
    logic         ge;
    logic [W-1:0] rem_nx;
    logic [W-1:0] quo_nx;
    logic         a_neg;
    logic         b_neg;

    assign a_neg = signed_mode & dividend[W-1];
    assign b_neg = signed_mode & divisor[W-1];

    always_comb begin
        st_d   = st_q;
        st_d.done = 1'b0;
        fin    = 1'b0;
        rem_sh = {st_q.rem, st_q.quo[W-1]};
        ge     = rem_sh >= {1'b0, st_q.dvsr};
        rem_nx = ge ? W'(rem_sh - {1'b0, st_q.dvsr}) : rem_sh[W-1:0];
        quo_nx = {st_q.quo[W-2:0], ge};
        if (start) begin
            st_d.busy  = 1'b1;
            st_d.cnt   = '0;
            st_d.rem   = '0;
            st_d.quo   = a_neg ? (W'(0) - dividend) : dividend;
            st_d.dvsr  = b_neg ? (W'(0) - divisor) : divisor;
            st_d.neg_q = a_neg ^ b_neg;
            st_d.neg_r = a_neg;
        end else if (st_q.busy) begin
            st_d.rem = rem_nx;
            st_d.quo = quo_nx;
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.cnt == LAST) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
                fin       = 1'b1;
            end
        end
        quo_out = st_q.neg_q ? (W'(0) - quo_nx) : quo_nx;
        rem_out = st_q.neg_r ? (W'(0) - rem_nx) : rem_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy = st_q.busy;
    assign done = st_q.done;

    // R8: a new divide never starts over one in flight
    p_start_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !st_q.busy);

    // R8: the last iteration is always followed by the done pulse
    p_fin_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> (done && !busy));
endmodule

// File: rtl/exu_core.sv
module exu_core
    import exu_pkg::*;
#(
    parameter int W     = 32,
    parameter int IMM_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [3:0]       op_code,
    input  logic             use_imm,
    input  logic [W-1:0]     src_a,
    input  logic [W-1:0]     src_b,
    input  logic [IMM_W-1:0] imm,
    output logic [W-1:0]     result,
    output logic [W-1:0]     flags,
    output logic [W-1:0]     hi,
    output logic [W-1:0]     lo,
    output logic             busy,
    output logic             done,
    output logic             exc_valid,
    output logic [EXC_W-1:0] exc_code
);
    typedef struct packed {
        logic [W-1:0]         result;
        logic [FLAG_BITS-1:0] flags;
        logic [W-1:0]         hi;
        logic [W-1:0]         lo;
        logic                 exc_valid;
        logic [EXC_W-1:0]     exc_code;
    } core_state_t;

    core_state_t st_d, st_q;

    logic [W-1:0]   opnd_b;
    logic           accept;
    logic [W-1:0]   alu_res;
    logic           alu_carry;
    logic           alu_ovf;
    logic           alu_hit;
    logic [2*W-1:0] prod;
    logic           div_start;
    logic           div_busy;
    logic           div_done;
    logic           div_fin;
    logic [W-1:0]   div_quo;
    logic [W-1:0]   div_rem;

    assign opnd_b = use_imm ? {{(W-IMM_W){imm[IMM_W-1]}}, imm} : src_b;
    assign accept = op_valid && !div_busy;

    exu_alu #(.W(W)) u_alu (
        .op     (op_code),
        .a      (src_a),
        .b      (opnd_b),
        .res    (alu_res),
        .carry  (alu_carry),
        .ovf    (alu_ovf),
        .is_alu (alu_hit)
    );

    exu_mul #(.W(W)) u_mul (
        .signed_mode (op_code == OP_MULS),
        .a           (src_a),
        .b           (opnd_b),
        .prod        (prod)
    );

    exu_div #(.W(W)) u_div (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (div_start),
        .signed_mode (op_code == OP_DIVS),
        .dividend    (src_a),
        .divisor     (opnd_b),
        .busy        (div_busy),
        .done        (div_done),
        .fin         (div_fin),
        .quo_out     (div_quo),
        .rem_out     (div_rem)
    );

    always_comb begin
        st_d           = st_q;
        st_d.exc_valid = 1'b0;
        st_d.exc_code  = '0;
        div_start      = 1'b0;
        if (accept) begin
            if (alu_hit) begin
                st_d.result               = alu_res;
                st_d.flags[FLAG_CARRY]    = alu_carry;
                st_d.flags[FLAG_OVF]      = alu_ovf;
                st_d.flags[FLAG_ZERO]     = (alu_res == '0);
                st_d.flags[FLAG_SIGN]     = alu_res[W-1];
                if (alu_ovf) begin
                    st_d.exc_valid = 1'b1;
                    st_d.exc_code  = EXC_OVERFLOW;
                end
            end else if (op_code == OP_MULS || op_code == OP_MULU) begin
                st_d.hi = prod[2*W-1:W];
                st_d.lo = prod[W-1:0];
            end else if (op_code == OP_DIVS || op_code == OP_DIVU) begin
                if (opnd_b == '0) begin
                    st_d.exc_valid = 1'b1;
                    st_d.exc_code  = EXC_DIV_ZERO;
                end else begin
                    div_start = 1'b1;
                end
            end
        end
        if (div_fin) begin
            st_d.hi = div_rem;
            st_d.lo = div_quo;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign result    = st_q.result;
    assign flags     = {{(W-FLAG_BITS){1'b0}}, st_q.flags};
    assign hi        = st_q.hi;
    assign lo        = st_q.lo;
    assign busy      = div_busy;
    assign done      = div_done;
    assign exc_valid = st_q.exc_valid;
    assign exc_code  = st_q.exc_code;

    p_ovf_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid && exc_code == EXC_OVERFLOW) |-> flags[FLAG_OVF]);

    p_div_zero_hilo_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid && exc_code == EXC_DIV_ZERO) |-> ($stable(hi) && $stable(lo)));

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_zero_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(accept && alu_hit && rst_n) |-> (flags[FLAG_ZERO] == (result == '0)));
endmodule

// File: tb/exu_core_bench.sv
module exu_core_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 14;

    typedef struct packed {
        logic [3:0]  op;
        logic        ui;
        logic [31:0] a;
        logic [31:0] b;
        logic [15:0] im;
        logic [31:0] res;
        logic [3:0]  fl;
    } vec_t;

    localparam vec_t VEC [NVEC] = '{
        '{4'd0, 1'b0, 32'h0000_0005, 32'h0000_0007, 16'h0, 32'h0000_000C, 4'h0},
        '{4'd0, 1'b0, 32'hFFFF_FFFF, 32'h0000_0001, 16'h0, 32'h0000_0000, 4'h5},
        '{4'd0, 1'b0, 32'h7FFF_FFFF, 32'h0000_0001, 16'h0, 32'h8000_0000, 4'hA},
        '{4'd1, 1'b0, 32'h0000_0005, 32'h0000_0007, 16'h0, 32'hFFFF_FFFE, 4'h8},
        '{4'd1, 1'b0, 32'h0000_0007, 32'h0000_0007, 16'h0, 32'h0000_0000, 4'h5},
        '{4'd1, 1'b0, 32'h8000_0000, 32'h0000_0001, 16'h0, 32'h7FFF_FFFF, 4'h3},
        '{4'd2, 1'b0, 32'hF0F0_F0F0, 32'hFF00_FF00, 16'h0, 32'h0FF0_0FF0, 4'h0},
        '{4'd3, 1'b1, 32'h0000_0000, 32'h1234_5678, 16'h8000, 32'hFFFF_8000, 4'h8},
        '{4'd4, 1'b0, 32'h0000_1234, 32'h0000_0000, 16'h0, 32'h0000_0000, 4'h4},
        '{4'd5, 1'b0, 32'h0000_0001, 32'h0000_0021, 16'h0, 32'h0000_0002, 4'h0},
        '{4'd6, 1'b0, 32'h8000_0000, 32'h0000_001F, 16'h0, 32'h0000_0001, 4'h0},
        '{4'd7, 1'b0, 32'h8000_0000, 32'h0000_0004, 16'h0, 32'hF800_0000, 4'h8},
        '{4'd0, 1'b1, 32'h0000_000A, 32'h0000_0000, 16'hFFFF, 32'h0000_0009, 4'h1},
        '{4'd1, 1'b1, 32'h0000_0003, 32'h0000_0000, 16'h0005, 32'hFFFF_FFFE, 4'h8}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [3:0]  op_code = '0;
    logic        use_imm = 1'b0;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic [15:0] imm = '0;
    logic [31:0] result, flags, hi, lo;
    logic        busy, done, exc_valid;
    logic [4:0]  exc_code;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    exu_core u_exu_core (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .use_imm(use_imm), .src_a(src_a), .src_b(src_b), .imm(imm),
        .result(result), .flags(flags), .hi(hi), .lo(lo), .busy(busy),
        .done(done), .exc_valid(exc_valid), .exc_code(exc_code)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [3:0] op, input logic ui, input logic [31:0] a,
                         input logic [31:0] b, input logic [15:0] im);
        @(negedge clk);
        op_valid = 1'b1; op_code = op; use_imm = ui; src_a = a; src_b = b; imm = im;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic wait_done(output int cycles);
        cycles = 0;
        while (!done && cycles < 100) begin
            @(negedge clk);
            cycles++;
        end
    endtask

    task automatic run_div(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                           input logic [31:0] eq, input logic [31:0] er, input string tag);
        int n;
        issue(op, 1'b0, a, b, 16'h0);
        wait_done(n);
        chk({tag, " R7 quotient in lo"}, lo, eq);
        chk({tag, " R7 remainder in hi"}, hi, er);
    endtask

    initial begin
        int n;
        logic [31:0] keep_res, keep_fl, keep_hi, keep_lo;
        repeat (3) @(negedge clk);
        chk("R10 reset result", result, 32'h0);
        chk("R10 reset flags", flags, 32'h0);
        chk("R10 reset hi", hi, 32'h0);
        chk("R10 reset lo", lo, 32'h0);
        chk("R10 reset busy/done/exc", {29'h0, busy, done, exc_valid}, 32'h0);
        rst_n = 1'b1;

        // R1 R2 R3 R4 R5: vector table
        for (int i = 0; i < NVEC; i++) begin
            issue(VEC[i].op, VEC[i].ui, VEC[i].a, VEC[i].b, VEC[i].im);
            chk($sformatf("R1/R2/R3 vec%0d result", i), result, VEC[i].res);
            chk($sformatf("R4 vec%0d flags", i), flags, {28'h0, VEC[i].fl});
            chk($sformatf("R5 vec%0d exc_valid", i), {31'h0, exc_valid}, {31'h0, VEC[i].fl[1]});
            if (VEC[i].fl[1])
                chk($sformatf("R5 vec%0d exc_code", i), {27'h0, exc_code}, 32'd2);
            @(negedge clk);
            chk($sformatf("R5 vec%0d exc pulse ends", i), {31'h0, exc_valid}, 32'h0);
        end

        // R6: multiply, result and flags untouched
        keep_res = result; keep_fl = flags;
        issue(4'd9, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'h0);
        chk("R6 mulu hi", hi, 32'hFFFF_FFFE);
        chk("R6 mulu lo", lo, 32'h0000_0001);
        chk("R6 mul keeps result", result, keep_res);
        chk("R6 mul keeps flags", flags, keep_fl);
        issue(4'd8, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'h0);
        chk("R6 muls -1*-1 hi", hi, 32'h0);
        chk("R6 muls -1*-1 lo", lo, 32'h1);
        issue(4'd8, 1'b1, 32'hFFFF_FFFE, 32'h0, 16'h0003);
        chk("R6 muls -2*3 hi", hi, 32'hFFFF_FFFF);
        chk("R6 muls -2*3 lo", lo, 32'hFFFF_FFFA);

        // R8: latency and busy
        issue(4'd11, 1'b0, 32'd100, 32'd7, 16'h0);
        chk("R8 busy after accept", {31'h0, busy}, 32'h1);
        wait_done(n);
        chk("R8 done latency", n, 32);
        chk("R8 busy low with done", {31'h0, busy}, 32'h0);
        chk("R7 divu 100/7 lo", lo, 32'd14);
        chk("R7 divu 100/7 hi", hi, 32'd2);
        @(negedge clk);
        chk("R8 done single pulse", {31'h0, done}, 32'h0);

        run_div(4'd10, 32'hFFFF_FFF9, 32'd2, 32'hFFFF_FFFD, 32'hFFFF_FFFF, "divs -7/2");
        run_div(4'd10, 32'd7, 32'hFFFF_FFFE, 32'hFFFF_FFFD, 32'd1, "divs 7/-2");
        run_div(4'd11, 32'hFFFF_FFFF, 32'd1, 32'hFFFF_FFFF, 32'd0, "divu max/1");

        // R8: operations while busy are ignored
        keep_res = result; keep_fl = flags;
        issue(4'd11, 1'b0, 32'd50, 32'd5, 16'h0);
        issue(4'd0, 1'b0, 32'd1, 32'd1, 16'h0);
        issue(4'd9, 1'b0, 32'd3, 32'd3, 16'h0);
        wait_done(n);
        chk("R8 add during busy ignored", result, keep_res);
        chk("R8 flags during busy unchanged", flags, keep_fl);
        chk("R8 mul during busy ignored, lo quotient", lo, 32'd10);
        chk("R8 hi remainder", hi, 32'd0);

        // R9: divide by zero
        keep_hi = hi; keep_lo = lo;
        issue(4'd11, 1'b0, 32'd5, 32'd0, 16'h0);
        chk("R9 div0 exc_valid", {31'h0, exc_valid}, 32'h1);
        chk("R9 div0 exc_code", {27'h0, exc_code}, 32'd0);
        chk("R9 div0 no busy", {31'h0, busy}, 32'h0);
        chk("R9 div0 hi unchanged", hi, keep_hi);
        chk("R9 div0 lo unchanged", lo, keep_lo);

        // R10: unused codes change nothing
        keep_res = result; keep_fl = flags;
        issue(4'd13, 1'b0, 32'h1234, 32'h5678, 16'h0);
        chk("R10 unused code result", result, keep_res);
        chk("R10 unused code flags", flags, keep_fl);
        chk("R10 unused code hi", hi, keep_hi);
        chk("R10 unused code exc", {31'h0, exc_valid}, 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule